// File: doc/BRIEF.md
# GPIO Function-Select and Output Register Bank

This block is the register core of a 54-pin general-purpose I/O controller. Every pin has a 3-bit function code. Ten codes are packed into each 32-bit function word. Code 0 makes the pin an input and code 1 makes it a driven output. The other six codes hand the pin to an alternate function; the codes in order for alternates 0 to 5 are 4, 5, 6, 7, 3, 2. The bank drives the raw code out on `fsel_o`, so the pad ring can route alternates. It also drives an output enable and an output value for each pin.

Output levels are never written with a read-modify-write. A host writes ones into a set register to raise pins and into a clear register to lower them, one bit per pin. Pins with a zero in the written word keep their latch. A pair of level registers returns each pad's level after it passes through a synchronizer.

The host port is a plain single-cycle word port. A write takes effect on the clock edge where `wr_i` is high. A read captures the selected word into `rdata_o` on the edge where `rd_i` is high.

Top module: `gpio_bank_top`

## Requirements
- R1: While `rst_ni` is low, every function field is 0, every output latch is 0, and `oe_o`, `out_o` and `fsel_o` are all zero.
- R2: A write to function word w (byte offset 4*w, w = 0..5) loads pin p = 10*w + k from write bits [3k+2:3k] for k = 0..9. The result shows on `fsel_o[3p+2:3p]` after that clock edge. Without a write, `fsel_o` holds.
- R3: Reading function word w returns each field exactly as last written, at the same bit positions as R2.
- R4: A write to offset 0x1C (pins 0..31) or 0x20 (pins 32..53, bit p-32) sets the output latch of each pin whose bit is 1. Bits that are 0 leave the latch alone.
- R5: A write to offset 0x28 (pins 0..31) or 0x2C (pins 32..53) clears the output latch of each pin whose bit is 1. Bits that are 0 leave the latch alone.
- R6: `oe_o[p]` is 1 exactly when pin p's code is 1. `out_o[p]` equals the pin's latch when `oe_o[p]` is 1 and is 0 otherwise. Set and clear writes update the latch in every mode.
- R7: Reading offset 0x34 returns pad levels of pins 0..31, and 0x38 returns pins 32..53 at bit p-32. A pad change is visible in a read issued two clock edges after the change.
- R8: Storage exists only for real pins. Bits 30 and 31 of every function word, fields for pins 54..59 in word 5, and bits 22..31 at 0x20, 0x2C and 0x38 read as zero, and writes to them are dropped. The set and clear offsets read as zero. Unmapped offsets read as zero.
- R9: `rdata_o` is updated only on a clock edge where `rd_i` is high and otherwise holds its value.
- R10: Every pin accepts all eight codes 0..7 and reports each one unchanged on `fsel_o` and on readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pad_i | input | 54 | Pad levels |
| fsel_o | output | 162 | Function code per pin, pin p at [3p+2:3p] |
| oe_o | output | 54 | Output enable per pin |
| out_o | output | 54 | Output value per pin |

## Verification
The bound checker checks the following on every cycle:
- the reset state of the outputs;
- that function codes hold between writes;
- that read data holds between reads;
- that no pin drives a value while its enable is low, and that each enable matches its code;
- the immediate effect of set and clear writes on bank 0.

Other behaviours only show in the bench's scenarios:
- the exact field packing and its readback;
- latches that are written while a pin is not an output and appear once it becomes one;
- the two-edge synchronizer delay on level reads;
- dropped writes to bits with no pin behind them.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned FN_W          = 3;
  localparam int unsigned FN_PER_WORD   = 10;
  localparam int unsigned OFS_FSEL      = 32'h00;
  localparam int unsigned OFS_SET       = 32'h1C;
  localparam int unsigned OFS_CLR       = 32'h28;
  localparam int unsigned OFS_LEV       = 32'h34;

  typedef enum logic [2:0] {
    FN_IN   = 3'd0,
    FN_OUT  = 3'd1,
    FN_ALT5 = 3'd2,
    FN_ALT4 = 3'd3,
    FN_ALT0 = 3'd4,
    FN_ALT1 = 3'd5,
    FN_ALT2 = 3'd6,
    FN_ALT3 = 3'd7
  } fn_code_e;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_FSEL = 2'd1,
    RD_LEV  = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FSEL_WORDS = 6,
  parameter int unsigned BANKS      = 2,
  parameter int unsigned IDX_W      = 3
) (
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [FSEL_WORDS-1:0] fsel_we_o,
  output logic [BANKS-1:0]      set_we_o,
  output logic [BANKS-1:0]      clr_we_o,
  output rd_kind_e              rd_kind_o,
  output logic [IDX_W-1:0]      rd_idx_o
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wa;
  assign wa = addr_i[ADDR_W-1:2];

  always_comb begin
    fsel_we_o = '0;
    set_we_o  = '0;
    clr_we_o  = '0;
    rd_kind_o = RD_ZERO;
    rd_idx_o  = '0;
    for (int i = 0; i < int'(FSEL_WORDS); i++) begin
      if (wa == WA_W'(OFS_FSEL / 4 + i)) begin
        fsel_we_o[i] = wr_i;
        rd_kind_o    = RD_FSEL;
        rd_idx_o     = IDX_W'(i);
      end
    end
    for (int b = 0; b < int'(BANKS); b++) begin
      if (wa == WA_W'(OFS_SET / 4 + b)) set_we_o[b] = wr_i;
      if (wa == WA_W'(OFS_CLR / 4 + b)) clr_we_o[b] = wr_i;
      if (wa == WA_W'(OFS_LEV / 4 + b)) begin
        rd_kind_o = RD_LEV;
        rd_idx_o  = IDX_W'(b);
      end
    end
  end
endmodule

// File: rtl/gpio_bank_fsel.sv
module gpio_bank_fsel
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 54,
  parameter int unsigned FSEL_WORDS = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [FSEL_WORDS-1:0]       fsel_we_i,
  input  logic [REG_W-1:0]            wdata_i,
  output logic [NUM_PINS*FN_W-1:0]    fsel_o,
  output logic [FSEL_WORDS*REG_W-1:0] word_rd_o
);
  logic [FN_W-1:0] fn_q [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int unsigned WRD = p / FN_PER_WORD;
    localparam int unsigned FLD = p % FN_PER_WORD;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             fn_q[p] <= FN_IN;
      else if (fsel_we_i[WRD]) fn_q[p] <= wdata_i[FLD*FN_W +: FN_W];
    end
    assign fsel_o[p*FN_W +: FN_W] = fn_q[p];
  end

  // fields with no pin and bits 31:30 stay zero
  always_comb begin
    word_rd_o = '0;
    for (int p = 0; p < int'(NUM_PINS); p++)
      word_rd_o[(p / FN_PER_WORD) * REG_W + (p % FN_PER_WORD) * FN_W +: FN_W] = fn_q[p];
  end
endmodule

// File: rtl/gpio_bank_out.sv
module gpio_bank_out
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned BANKS    = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BANKS-1:0]         set_we_i,
  input  logic [BANKS-1:0]         clr_we_i,
  input  logic [REG_W-1:0]         wdata_i,
  input  logic [NUM_PINS*FN_W-1:0] fsel_i,
  output logic [NUM_PINS-1:0]      oe_o,
  output logic [NUM_PINS-1:0]      out_o
);
  logic lat_q [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int unsigned BNK = p / REG_W;
    localparam int unsigned BIT = p % REG_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             lat_q[p] <= 1'b0;
      else if (set_we_i[BNK] && wdata_i[BIT]) lat_q[p] <= 1'b1;
      else if (clr_we_i[BNK] && wdata_i[BIT]) lat_q[p] <= 1'b0;
    end
    assign oe_o[p]  = (fsel_i[p*FN_W +: FN_W] == FN_OUT);
    assign out_o[p] = lat_q[p] & oe_o[p];
  end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] lvl_o
);
  logic [NUM_PINS-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= pad_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 54,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         rdata_o,
  input  logic [NUM_PINS-1:0]      pad_i,
  output logic [NUM_PINS*FN_W-1:0] fsel_o,
  output logic [NUM_PINS-1:0]      oe_o,
  output logic [NUM_PINS-1:0]      out_o
);
  localparam int unsigned FSEL_WORDS = (NUM_PINS + FN_PER_WORD - 1) / FN_PER_WORD;
  localparam int unsigned BANKS      = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int unsigned IDX_W      = 3;

  logic [FSEL_WORDS-1:0]       fsel_we;
  logic [BANKS-1:0]            set_we, clr_we;
  rd_kind_e                    rd_kind;
  logic [IDX_W-1:0]            rd_idx;
  logic [FSEL_WORDS*REG_W-1:0] fsel_words;
  logic [NUM_PINS-1:0]         lvl;
  logic [BANKS*REG_W-1:0]      lvl_words;
  logic [REG_W-1:0]            rdata_q;

  gpio_bank_decode #(
    .ADDR_W(ADDR_W), .FSEL_WORDS(FSEL_WORDS), .BANKS(BANKS), .IDX_W(IDX_W)
  ) u_dec (
    .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .fsel_we_o(fsel_we), .set_we_o(set_we), .clr_we_o(clr_we),
    .rd_kind_o(rd_kind), .rd_idx_o(rd_idx)
  );

  gpio_bank_fsel #(.NUM_PINS(NUM_PINS), .FSEL_WORDS(FSEL_WORDS)) u_fsel (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsel_we_i(fsel_we), .wdata_i(wdata_i),
    .fsel_o(fsel_o), .word_rd_o(fsel_words)
  );

  gpio_bank_out #(.NUM_PINS(NUM_PINS), .BANKS(BANKS)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_we_i(set_we), .clr_we_i(clr_we),
    .wdata_i(wdata_i), .fsel_i(fsel_o), .oe_o(oe_o), .out_o(out_o)
  );

  gpio_bank_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pad_i(pad_i), .lvl_o(lvl)
  );

  assign lvl_words = (BANKS*REG_W)'(lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) begin
      case (rd_kind)
        RD_FSEL: rdata_q <= fsel_words[rd_idx*REG_W +: REG_W];
        RD_LEV:  rdata_q <= lvl_words[rd_idx*REG_W +: REG_W];
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_i,
  input logic                     rd_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [REG_W-1:0]         wdata_i,
  input logic [REG_W-1:0]         rdata_o,
  input logic [NUM_PINS*FN_W-1:0] fsel_o,
  input logic [NUM_PINS-1:0]      oe_o,
  input logic [NUM_PINS-1:0]      out_o
);
  localparam int unsigned LO = (NUM_PINS < REG_W) ? NUM_PINS : REG_W;

  logic set0, clr0;
  assign set0 = addr_i[ADDR_W-1:2] == (ADDR_W-2)'(OFS_SET / 4);
  assign clr0 = addr_i[ADDR_W-1:2] == (ADDR_W-2)'(OFS_CLR / 4);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (fsel_o == '0 && oe_o == '0 && out_o == '0));

  assert_fsel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(fsel_o));

  assert_set_raises_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && set0) |=> &(out_o[LO-1:0] | ~oe_o[LO-1:0] | ~$past(wdata_i[LO-1:0])));

  assert_clr_lowers_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && clr0) |=> ~|(out_o[LO-1:0] & $past(wdata_i[LO-1:0])));

  assert_out_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ~|(out_o & ~oe_o));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assert_oe_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_o[p] == (fsel_o[p*FN_W +: FN_W] == FN_OUT));
  end

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind gpio_bank_top gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_bank_top_tb_top.sv
module gpio_bank_top_tb_top;
  localparam int NP = 54;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pad = '0;
  logic [NP*3-1:0] fsel;
  logic [NP-1:0] oe, outv;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] m_fn [NP];
  logic       m_lat [NP];
  logic [NP-1:0] m_pad;

  always #10ns clk = ~clk;

  gpio_bank_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad),
    .fsel_o(fsel), .oe_o(oe), .out_o(outv)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a) / 4;
    if (w < 6) begin
      for (int k = 0; k < 10; k++) if (w*10 + k < NP) m_fn[w*10+k] = d[k*3 +: 3];
    end else if (a == 8'h1C || a == 8'h20) begin
      for (int k = 0; k < 32; k++) if ((w-7)*32 + k < NP && d[k]) m_lat[(w-7)*32+k] = 1'b1;
    end else if (a == 8'h28 || a == 8'h2C) begin
      for (int k = 0; k < 32; k++) if ((w-10)*32 + k < NP && d[k]) m_lat[(w-10)*32+k] = 1'b0;
    end
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    int w = int'(a) / 4;
    if (w < 6) begin
      for (int k = 0; k < 10; k++) if (w*10 + k < NP) r[k*3 +: 3] = m_fn[w*10+k];
    end else if (a == 8'h34 || a == 8'h38) begin
      for (int k = 0; k < 32; k++) if ((w-13)*32 + k < NP) r[k] = m_pad[(w-13)*32+k];
    end
    return r;
  endfunction

  function automatic logic [NP*3-1:0] exp_fsel();
    logic [NP*3-1:0] v;
    for (int p = 0; p < NP; p++) v[p*3 +: 3] = m_fn[p];
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = (m_fn[p] == 3'd1);
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = (m_fn[p] == 3'd1) & m_lat[p];
    return v;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic chk_pins(input string req);
    chk({req, " fsel_o"}, fsel, exp_fsel());
    chk({req, " oe_o"}, oe, exp_oe());
    chk({req, " out_o"}, outv, exp_out());
  endtask

  task automatic chk_read(input string req, input logic [7:0] a);
    logic [31:0] d;
    do_read(a, d);
    chk(req, d, exp_read(a));
  endtask

  task automatic set_pad(input logic [NP-1:0] v);
    @(negedge clk);
    pad = v; m_pad = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, hold;
    logic [7:0] alist [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h20, 8'h28, 8'h2C};
    void'($urandom(32'h5A17));
    for (int p = 0; p < NP; p++) begin m_fn[p] = '0; m_lat[p] = 1'b0; end
    m_pad = '0;
    repeat (4) @(negedge clk);
    chk_pins("R1 reset");
    rst_n = 1'b1;
    chk_read("R1 fsel word0 after reset", 8'h00);

    // R2/R3 packing: pin0 output, pin1 alt0, pin9 alt3
    do_write(8'h00, (32'd7 << 27) | (32'd4 << 3) | 32'd1);
    chk_pins("R2 pack word0");
    chk_read("R3 readback word0", 8'h00);

    // R4 set, R6 latch while not output
    do_write(8'h1C, 32'h3);
    chk_pins("R4 set bits 0,1");
    chk(("R6 alt pin not driven"), outv[1], 1'b0);
    do_write(8'h00, (32'd1 << 3) | 32'd1);
    chk(("R6 latched value appears"), outv[1:0], 2'b11);

    // R5 clear, zero bits no effect
    do_write(8'h28, 32'h0);
    chk_pins("R5 clear zero word");
    do_write(8'h28, 32'h1);
    chk_pins("R5 clear bit0");
    chk("R5 pin1 kept", outv[1], 1'b1);

    // R8 unused bits
    do_write(8'h14, 32'hFFFF_FFFF);
    chk_read("R8 word5 upper fields zero", 8'h14);
    do_write(8'h04, 32'hFFFF_FFFF);
    chk_read("R8 word1 bits 31:30 zero", 8'h04);
    chk_read("R8 set reads zero", 8'h1C);
    chk_read("R8 clr reads zero", 8'h2C);
    chk_read("R8 unmapped reads zero", 8'h40);
    do_write(8'h20, 32'hFFC0_0000);
    chk_pins("R8 set high bits dropped");

    // R10 every code on pin 53 (word5 field 3)
    for (int c = 0; c < 8; c++) begin
      do_write(8'h14, 32'(c) << 9);
      chk_pins("R10 code sweep");
      chk_read("R10 code readback", 8'h14);
    end

    // R7 levels
    set_pad({22'h2A_AAAA, 32'h5555_5555} & {NP{1'b1}});
    chk_read("R7 level bank0", 8'h34);
    chk_read("R7 level bank1", 8'h38);
    @(negedge clk); pad = ~pad; m_pad = pad;
    @(negedge clk);
    chk_read("R7 level after two edges", 8'h34);

    // R9 hold
    do_read(8'h34, hold);
    set_pad('1);
    chk("R9 rdata holds without rd", rdata, hold);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 8) begin
        logic [7:0] a = alist[$urandom_range(0, 9)];
        d = $urandom();
        if (a < 8'h18 && $urandom_range(0, 1) == 1) d = d & 32'h2492_4924 | 32'h0924_9249;
        do_write(a, d);
        chk_pins((a < 8'h18) ? "R2 random fsel" : (a < 8'h28) ? "R4 random set" : "R5 random clr");
      end else if (op == 8) begin
        set_pad({$urandom(), $urandom()});
        chk_read("R7 random level", $urandom_range(0, 1) ? 8'h34 : 8'h38);
      end else begin
        chk_read("R3 random readback", 8'(4 * $urandom_range(0, 5)));
      end
    end
    chk_pins("R6 final");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule